// File: doc/BRIEF.md
# Banked General-Purpose Pin Register Group

This block puts a set of general-purpose pin ports into a byte-wide configuration register window. Every port owns a group of four consecutive indices starting at a base index aligned to four. One register holds the pin directions, one is the output latch, one returns the pin levels, and one picks open-drain or push-pull drive for each pin. A port may carry fewer than eight pins. The block connects on one side to the register strobe interface of a keyed configuration port. On the other side it connects to the pad signals of each pin: output enable, output value and input level.

The window is open only while `cfg_win_en` is high, which is the case when the pin logical device has been selected upstream. Software sets the output latch first and then changes the direction. The pin then drives the preset level on the first cycle it is an output. Port bases and widths are parameters. By default there are nine ports, at 0xF0, 0xE0, 0xD0, 0xC0, 0xB0, 0xA0, 0x90, 0x80 and 0x88, with widths 6, 8, 8, 4, 8, 5, 8, 7 and 8 pins. Pad vectors give every port eight slots, and port p bit b sits at index 8*p+b.

Top module: `gpio_bank_group`

## Requirements
- R1: After synchronous reset every pin is an input, all output latches are 0 and all pins are in open-drain mode. Every register reads 0 and `pad_oe` and `pad_out` are all 0.
- R2: Within a port's group the registers are direction at base+0, output latch at base+1, pin status at base+2 and drive mode at base+3. A write lands on the clock edge where `cfg_we` is high, and reads of the register are combinational from `cfg_addr`.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. In push-pull mode (mode bit 1), `pad_out` carries the latch bit, and `pad_oe` is set exactly when the pin is an output.
- R4: In open-drain mode (mode bit 0), an output pin with latch 0 asserts `pad_oe` with `pad_out` 0. With latch 1 the pad is released (`pad_oe` 0). `pad_out` is 0 for every open-drain pin.
- R5: A latch value written while the pin is an input does not reach the pad. The pin drives it from the cycle after its direction bit is set.
- R6: Pin status returns `pad_in` through a two-flop synchronizer, whatever the direction. A level held for two clock edges is readable.
- R7: Bits at or above a port's width read 0, ignore writes, and keep `pad_oe` and `pad_out` at 0.
- R8: The pin status register is read-only, and a write to base+2 changes no state.
- R9: While `cfg_win_en` is low, writes have no effect and `cfg_rdata` is 0.
- R10: An index outside every port group reads 0, and writing to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_en | input | 1 | Pin logical device selected; opens the register window |
| cfg_addr | input | 8 | Register index inside the window |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe, one cycle per write |
| cfg_rdata | output | 8 | Read data of the indexed register |
| pad_in | input | 8*NPORT | Pad input levels, port p in bits 8p+7..8p |
| pad_oe | output | 8*NPORT | Pad output enables |
| pad_out | output | 8*NPORT | Pad output values |

## Verification
Directed sequences cover four cases:
- latch presets before a direction change, which separates R5 from a design that drives the latch with no regard to direction;
- open-drain latch patterns with mixed 0 and 1 bits, which show whether release and drive-low are swapped;
- all-ones writes to narrow ports, which expose unmasked bits;
- writes to the status index and with the window closed.

Random writes mix in-group, unmapped and closed-window accesses across all ports and offsets, so that a wrong base decode or a wrong offset decode shows up at the pads or on read-back. Random pad levels read through the status register, both with pins set as inputs and as outputs, check the synchronizer and that the status read ignores direction.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

    localparam int PW        = 8;
    localparam int NPORT_DEF = 9;

    typedef enum logic [1:0] {
        RS_DIR  = 2'd0,
        RS_DOUT = 2'd1,
        RS_STAT = 2'd2,
        RS_MODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PW-1:0] dir;
        logic [PW-1:0] dout;
        logic [PW-1:0] mode;
    } port_cfg_t;

    // port 0 in the low byte / nibble
    localparam logic [NPORT_DEF*8-1:0] DEF_BASES =
        {8'h88, 8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0, 8'hF0};
    localparam logic [NPORT_DEF*4-1:0] DEF_WIDTHS =
        {4'd8, 4'd7, 4'd8, 4'd5, 4'd8, 4'd4, 4'd8, 4'd8, 4'd6};

    function automatic logic [PW-1:0] width_mask(input logic [3:0] w);
        logic [PW-1:0] m;
        for (int i = 0; i < PW; i++) begin
            m[i] = (i < int'(w));
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_cluster_regs.sv
module gpio_cluster_regs
    import gpio_grp_pkg::*;
#(
    parameter logic [7:0]    BASE = 8'hF0,
    parameter logic [PW-1:0] MASK = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_en,
    input  logic [7:0]    addr,
    input  logic [PW-1:0] wdata,
    input  logic          we,
    output port_cfg_t     cfg,
    output logic          hit,
    output reg_sel_e      sel
);

    assign hit = win_en && (addr[7:2] == BASE[7:2]);
    assign sel = reg_sel_e'(addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && hit) begin
            case (sel)
                RS_DIR:  cfg.dir  <= wdata & MASK;
                RS_DOUT: cfg.dout <= wdata & MASK;
                RS_MODE: cfg.mode <= wdata & MASK;
                default: ;   // status index is read-only
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_grp_pkg::*;
#(
    parameter logic [PW-1:0] MASK = 8'hFF
) (
    input  port_cfg_t     cfg,
    output logic [PW-1:0] oe,
    output logic [PW-1:0] out
);

    // push-pull: enable follows direction; open-drain: enable only to pull low
    always_comb begin
        oe  = MASK & cfg.dir & (cfg.mode | ~cfg.dout);
        out = MASK & cfg.dout & cfg.mode;
    end

endmodule

// File: rtl/gpio_bank_group.sv
module gpio_bank_group
    import gpio_grp_pkg::*;
#(
    parameter int                 NPORT  = NPORT_DEF,
    parameter logic [NPORT*8-1:0] BASES  = DEF_BASES,
    parameter logic [NPORT*4-1:0] WIDTHS = DEF_WIDTHS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_win_en,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    input  logic                  cfg_we,
    output logic [7:0]            cfg_rdata,
    input  logic [NPORT*PW-1:0]   pad_in,
    output logic [NPORT*PW-1:0]   pad_oe,
    output logic [NPORT*PW-1:0]   pad_out
);

    localparam int PADW = NPORT * PW;

    logic [PW-1:0] rd_vec [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [7:0]    PBASE = BASES[p*8 +: 8];
        localparam logic [PW-1:0] PMASK = width_mask(WIDTHS[p*4 +: 4]);

        port_cfg_t     cfg;
        logic          hit;
        reg_sel_e      sel;
        logic [PW-1:0] status;

        gpio_cluster_regs #(.BASE(PBASE), .MASK(PMASK)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .win_en (cfg_win_en),
            .addr   (cfg_addr),
            .wdata  (cfg_wdata),
            .we     (cfg_we),
            .cfg    (cfg),
            .hit    (hit),
            .sel    (sel)
        );

        gpio_pin_sync #(.W(PW)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pad_in[p*PW +: PW] & PMASK),
            .q   (status)
        );

        gpio_pad_drive #(.MASK(PMASK)) u_drv (
            .cfg (cfg),
            .oe  (pad_oe[p*PW +: PW]),
            .out (pad_out[p*PW +: PW])
        );

        always_comb begin
            rd_vec[p] = '0;
            if (hit) begin
                case (sel)
                    RS_DIR:  rd_vec[p] = cfg.dir;
                    RS_DOUT: rd_vec[p] = cfg.dout;
                    RS_STAT: rd_vec[p] = status;
                    RS_MODE: rd_vec[p] = cfg.mode;
                    default: rd_vec[p] = '0;
                endcase
            end
        end
    end

    // groups never overlap, so an OR of the per-port reads is the mux
    always_comb begin
        cfg_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            cfg_rdata = cfg_rdata | rd_vec[p];
        end
    end

    logic unused_padw;
    assign unused_padw = (PADW == 0);

endmodule

// File: rtl/gpio_bank_group_chk.sv
module gpio_bank_group_chk
    import gpio_grp_pkg::*;
#(
    parameter int                 NPORT  = NPORT_DEF,
    parameter logic [NPORT*8-1:0] BASES  = DEF_BASES,
    parameter logic [NPORT*4-1:0] WIDTHS = DEF_WIDTHS
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_win_en,
    input logic [7:0]          cfg_addr,
    input logic [7:0]          cfg_rdata,
    input logic [NPORT*PW-1:0] pad_oe,
    input logic [NPORT*PW-1:0] pad_out
);

    logic [NPORT*PW-1:0] impl;
    for (genvar p = 0; p < NPORT; p++) begin : g_m
        assign impl[p*PW +: PW] = width_mask(WIDTHS[p*4 +: 4]);
    end

    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (cfg_addr[7:2] == BASES[p*8+2 +: 6]) mapped = 1'b1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0));

    a_r7_unimpl_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out) & ~impl) == '0);

    a_r9_closed_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg_win_en |-> cfg_rdata == 8'h00);

    a_r9_closed_no_change: assert property (@(posedge clk) disable iff (rst)
        !cfg_win_en |=> ($stable(pad_oe) && $stable(pad_out)));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_win_en && !mapped) |-> cfg_rdata == 8'h00);

endmodule

bind gpio_bank_group gpio_bank_group_chk #(
    .NPORT(NPORT), .BASES(BASES), .WIDTHS(WIDTHS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_win_en (cfg_win_en),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out)
);

// File: tb/sim_gpio_bank_group.sv
`timescale 1ns/1ps
module sim_gpio_bank_group;

    localparam int NP = 9;
    localparam int PADW = NP * 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst, win, we;
    logic [7:0]      addr, wdata, rdata;
    logic [PADW-1:0] pin, oe, out;

    gpio_bank_group u0 (
        .clk(clk), .rst(rst), .cfg_win_en(win), .cfg_addr(addr),
        .cfg_wdata(wdata), .cfg_we(we), .cfg_rdata(rdata),
        .pad_in(pin), .pad_oe(oe), .pad_out(out)
    );

    logic [7:0] bases  [NP] = '{8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0, 8'h90, 8'h80, 8'h88};
    int         widths [NP] = '{6, 8, 8, 4, 8, 5, 8, 7, 8};
    logic [7:0] m_dir [NP], m_dout [NP], m_mode [NP];

    int checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [7:0] msk(int p);
        return 8'((1 << widths[p]) - 1);
    endfunction

    function automatic logic [PADW-1:0] exp_oe();
        logic [PADW-1:0] r;
        for (int p = 0; p < NP; p++)
            r[p*8 +: 8] = m_dir[p] & (m_mode[p] | ~m_dout[p]) & msk(p);
        return r;
    endfunction

    function automatic logic [PADW-1:0] exp_out();
        logic [PADW-1:0] r;
        for (int p = 0; p < NP; p++)
            r[p*8 +: 8] = m_dout[p] & m_mode[p] & msk(p);
        return r;
    endfunction

    // assumes pin has been stable for at least two edges
    function automatic logic [7:0] exp_rd(logic en, logic [7:0] a);
        logic [7:0] r = 8'h00;
        if (en)
            for (int p = 0; p < NP; p++)
                if (a[7:2] == bases[p][7:2])
                    case (a[1:0])
                        2'd0: r = m_dir[p];
                        2'd1: r = m_dout[p];
                        2'd2: r = pin[p*8 +: 8] & msk(p);
                        default: r = m_mode[p];
                    endcase
        return r;
    endfunction

    task automatic chk(string tag, logic [PADW-1:0] act, logic [PADW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pads(string tag);
        chk({tag, " oe"}, oe, exp_oe());
        chk({tag, " out"}, out, exp_out());
    endtask

    task automatic wr(logic en, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        win = en; addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (en)
            for (int p = 0; p < NP; p++)
                if (a[7:2] == bases[p][7:2])
                    case (a[1:0])
                        2'd0: m_dir[p]  = d & msk(p);
                        2'd1: m_dout[p] = d & msk(p);
                        2'd3: m_mode[p] = d & msk(p);
                        default: ;
                    endcase
    endtask

    task automatic rd(string tag, logic en, logic [7:0] a);
        @(negedge clk);
        win = en; addr = a; we = 1'b0;
        #1;
        chk(tag, {{(PADW-8){1'b0}}, rdata}, {{(PADW-8){1'b0}}, exp_rd(en, a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; win = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin = '0;
        for (int p = 0; p < NP; p++) begin
            m_dir[p] = '0; m_dout[p] = '0; m_mode[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_pads("R1");
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < 4; o++) rd("R1", 1'b1, bases[p] | 8'(o));

        // R5 preset latch, then switch to output; R3 push-pull drive; R2 layout
        wr(1'b1, 8'hE1, 8'hA5);
        wr(1'b1, 8'hE3, 8'hFF);
        chk_pads("R5");
        wr(1'b1, 8'hE0, 8'hFF);
        chk_pads("R3");
        rd("R2", 1'b1, 8'hE1);

        // R4 open-drain on port 2
        wr(1'b1, 8'hD1, 8'h0F);
        wr(1'b1, 8'hD0, 8'hFF);
        chk_pads("R4");

        // R7 narrow ports ignore upper bits
        wr(1'b1, 8'hF0, 8'hFF);
        wr(1'b1, 8'hF3, 8'hFF);
        wr(1'b1, 8'hC1, 8'hFF);
        rd("R7", 1'b1, 8'hF0);
        rd("R7", 1'b1, 8'hC1);
        chk_pads("R7");

        // R8 status read-only; R6 synchronized read with mixed direction
        pin = {PADW{1'b1}};
        repeat (3) @(negedge clk);
        wr(1'b1, 8'hD2, 8'h00);
        rd("R8", 1'b1, 8'hD2);
        rd("R6", 1'b1, 8'hA2);
        chk_pads("R8");

        // R9 closed window
        wr(1'b0, 8'hB0, 8'hFF);
        chk_pads("R9");
        rd("R9", 1'b0, 8'hE1);

        // R10 unmapped index
        wr(1'b1, 8'h04, 8'hFF);
        chk_pads("R10");
        rd("R10", 1'b1, 8'h04);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [7:0] a;
            r = int'($urandom % 8);
            if ($urandom % 8 == 0) a = 8'($urandom);
            else a = bases[$urandom % NP] | 8'($urandom % 4);
            if (r < 5) begin
                wr(($urandom % 6) != 0, a, 8'($urandom));
                chk_pads("R3/R4 random");
            end else if (r < 7) begin
                rd("R2 random", ($urandom % 6) != 0, a);
            end else begin
                for (int k = 0; k < PADW; k += 32) pin[k +: 8] = 8'($urandom);
                pin = {$urandom, $urandom, $urandom} ^ pin;
                repeat (3) @(negedge clk);
                rd("R6 random", 1'b1, bases[$urandom % NP] | 8'h02);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule